// File: doc/BRIEF.md
# Cascadable Phase Accumulator

This block is the frequency core of a digitally synthesized oscillator. On every rising clock edge it adds a 48-bit phase step to a 48-bit phase register and keeps only the low 48 bits of the result. With a clock frequency Fclk and a step value S, the phase wraps at a rate of Fclk·S/2^48, which is the output frequency. The 13 most significant phase bits go to a separate waveform stage that is outside this block. The block also brings out the full phase word so that it can be read or cascaded.

Two units chain into a 96-bit accumulator. The wrap pulse of the low-order unit drives the carry input of the high-order unit. A carry input of 1 adds one to the step for that cycle. The carry output is a registered, one-cycle pulse that marks each wrap. Because that pulse is registered, the high-order word trails the low-order carries by exactly one cycle.

The adder is not pipelined. The phase word and the carry output are both registered, and they reflect the inputs sampled at the previous clock edge. The latency is therefore one cycle. A new step value takes effect at the next edge without disturbing the phase, so frequency changes are phase-continuous. An asynchronous active-low reset clears the phase and the carry output.

Top module: `phacc_top`

## Requirements
- R1: At each rising clock edge the phase becomes (phase + step + carry-in) mod 2^48, visible one cycle after the inputs are presented.
- R2: With carry-in at 1 the effective step for that edge is one larger; with step 0 and carry-in 1 the phase advances by exactly 1.
- R3: The carry output is 1 in the cycle after an edge where phase + step + carry-in reached 2^48 or more, and 0 after any edge where it did not, so each wrap gives a pulse one cycle long.
- R4: The 13-bit top output always equals phase bits 47 down to 35.
- R5: Driving reset low clears the phase and the carry output at once, without waiting for a clock edge.
- R6: Changing the step never resets or jumps the phase: the first edge after the change adds the new step to the phase that was already accumulated.
- R7: A unit whose carry input is driven by another unit's carry output counts that unit's wraps, one cycle late, so that the pair forms a 96-bit accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates happen on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseInc | input | 48 | Phase step added each cycle |
| carryIn | input | 1 | Adds one to the step for the current edge (cascade input) |
| phase | output | 48 | Registered phase word |
| phaseTop | output | 13 | Phase bits 47..35 for the waveform stage |
| carryOut | output | 1 | One-cycle pulse after each 48-bit wrap |

## Verification
A corrupted phase bit does not go away by itself. It stays in the phase word for every later cycle. The very next sample of the phase output therefore differs from the running sum kept in the bench. A fault in the top bits also shows on the 13-bit output in the same cycle. A wrong wrap decision shows on the carry output one cycle after the faulty edge. In the cascade it then shows as an off-by-one count in the high-order unit one cycle after that.

// File: rtl/phacc_pkg.sv
package phacc_pkg;
  // Strobes from the control side into the datapath adder.
  typedef struct packed {
    logic addOne;   // raise the effective step by one this edge
    logic advance;  // allow the phase register to take the sum
  } accStrobe_t;
endpackage

// File: rtl/phacc_dp.sv
module phacc_dp
  import phacc_pkg::*;
#(
  parameter int PHASE_W = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] stepIn,
  input  accStrobe_t         strobe,
  output logic [PHASE_W-1:0] phaseQ,
  output logic               sumOvf
);
  localparam int SUM_W = PHASE_W + 1;

  logic [SUM_W-1:0] sumWide;

  // One wide add; the extra bit is the wrap indication.
  always_comb begin
    sumWide = {1'b0, phaseQ} + {1'b0, stepIn} + {{PHASE_W{1'b0}}, strobe.addOne};
  end

  assign sumOvf = sumWide[PHASE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (strobe.advance) begin
      phaseQ <= sumWide[PHASE_W-1:0];
    end
  end
endmodule

// File: rtl/phacc_ctrl.sv
module phacc_ctrl
  import phacc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       carryIn,
  input  logic       sumOvf,
  output accStrobe_t strobe,
  output logic       carryOutQ
);
  always_comb begin
    strobe.addOne  = carryIn;
    strobe.advance = 1'b1;
  end

  // Wrap pulse registered on the same edge as the phase word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryOutQ <= 1'b0;
    end else begin
      carryOutQ <= sumOvf & strobe.advance;
    end
  end
endmodule

// File: rtl/phacc_top.sv
module phacc_top
  import phacc_pkg::*;
#(
  parameter int PHASE_W = 48,
  parameter int TOP_W   = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] phaseInc,
  input  logic               carryIn,
  output logic [PHASE_W-1:0] phase,
  output logic [TOP_W-1:0]   phaseTop,
  output logic               carryOut
);
  localparam int TOP_LSB = PHASE_W - TOP_W;

  accStrobe_t         strobe;
  logic               sumOvf;
  logic [PHASE_W-1:0] phaseQ;

  phacc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .carryIn   (carryIn),
    .sumOvf    (sumOvf),
    .strobe    (strobe),
    .carryOutQ (carryOut)
  );

  phacc_dp #(.PHASE_W(PHASE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stepIn (phaseInc),
    .strobe (strobe),
    .phaseQ (phaseQ),
    .sumOvf (sumOvf)
  );

  assign phase    = phaseQ;
  assign phaseTop = phaseQ[PHASE_W-1:TOP_LSB];
endmodule

// File: rtl/phacc_chk.sv
module phacc_chk #(
  parameter int PHASE_W = 48,
  parameter int TOP_W   = 13
) (
  input logic               clk,
  input logic               rstN,
  input logic [PHASE_W-1:0] phaseInc,
  input logic               carryIn,
  input logic [PHASE_W-1:0] phase,
  input logic [TOP_W-1:0]   phaseTop,
  input logic               carryOut
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  function automatic logic [PHASE_W:0] wideSum(input logic [PHASE_W-1:0] a,
                                               input logic [PHASE_W-1:0] b,
                                               input logic c);
    return {1'b0, a} + {1'b0, b} + {{PHASE_W{1'b0}}, c};
  endfunction

  // R1 / R2: the phase follows the modular sum of the previous cycle's inputs
  p_step_r1: assert property (@(posedge clk) disable iff (!rstN || !armed)
    phase == PHASE_W'(wideSum($past(phase), $past(phaseInc), $past(carryIn))));

  // R3: carry output is exactly the wrap of the previous sum
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN || !armed)
    {carryOut, phase} == wideSum($past(phase), $past(phaseInc), $past(carryIn)));

  // R4: top output tracks the upper phase bits
  p_top_r4: assert property (@(posedge clk) disable iff (!rstN)
    phaseTop == phase[PHASE_W-1 -: TOP_W]);

  // R6: zero step and no carry leaves the phase untouched and gives no pulse
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(phaseInc) == '0 && !$past(carryIn)) |-> ($stable(phase) && !carryOut));

  // R5: while reset is held the state is cleared
  always_ff @(posedge clk) begin
    if (!rstN) begin
      a_reset_r5: assert (phase == '0 && !carryOut);
    end
  end
endmodule

bind phacc_top phacc_chk #(.PHASE_W(PHASE_W), .TOP_W(TOP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .phaseInc (phaseInc),
  .carryIn  (carryIn),
  .phase    (phase),
  .phaseTop (phaseTop),
  .carryOut (carryOut)
);

// File: tb/phacc_top_tb.sv
`timescale 1ns/1ps
module phacc_top_tb;
  typedef struct packed {
    logic        cin;
    logic [47:0] inc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 48'h0000_0000_0001},
    '{1'b1, 48'h0000_0000_0000},
    '{1'b0, 48'h0000_0000_0800},
    '{1'b0, 48'hFFFF_FFFF_FFFF},
    '{1'b0, 48'h0000_0000_0000},
    '{1'b1, 48'hFFFF_FFFF_FFFF},
    '{1'b0, 48'h8000_0000_0000},
    '{1'b0, 48'h8000_0000_0000},
    '{1'b0, 48'h0000_0008_0000},
    '{1'b1, 48'h0123_4567_89AB},
    '{1'b0, 48'h7FFF_FFFF_FFFF},
    '{1'b0, 48'h0000_0000_0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [47:0] phaseInc = '0;
  logic        carryIn = 1'b0;
  logic [47:0] phase;
  logic [12:0] phaseTop;
  logic        carryOut;

  logic [47:0] hiInc = '0;
  logic [47:0] hiPhase;
  logic [12:0] hiTop;
  logic        hiCarry;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  phacc_top u_dut (
    .clk(clk), .rstN(rstN), .phaseInc(phaseInc), .carryIn(carryIn),
    .phase(phase), .phaseTop(phaseTop), .carryOut(carryOut)
  );

  phacc_top u_hi (
    .clk(clk), .rstN(rstN), .phaseInc(hiInc), .carryIn(carryOut),
    .phase(hiPhase), .phaseTop(hiTop), .carryOut(hiCarry)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one edge and land 1 ns after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    #1 rstN = 1'b0;
    #1;
    chk("R5 phase cleared", 64'(phase), 64'h0);
    chk("R5 carry cleared", 64'(carryOut), 64'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  logic [48:0] model;
  logic [47:0] mPhase;
  int carries;

  initial begin
    // reset state
    doReset();
    chk("R4 top after reset", 64'(phaseTop), 64'h0);
    mPhase = '0;

    // vector table
    for (int i = 0; i < NV; i++) begin
      phaseInc = VEC[i].inc;
      carryIn  = VEC[i].cin;
      step();
      model  = {1'b0, mPhase} + {1'b0, VEC[i].inc} + {48'h0, VEC[i].cin};
      mPhase = model[47:0];
      chk("R1 R2 R6 phase", 64'(phase), 64'(mPhase));
      chk("R3 carry", 64'(carryOut), 64'(model[48]));
      chk("R4 top", 64'(phaseTop), 64'(mPhase[47:35]));
    end

    // asynchronous reset mid-cycle, no clock edge in between
    phaseInc = 48'h1234_5678_9ABC;
    carryIn  = 1'b0;
    step();
    step();
    @(negedge clk);
    rstN = 1'b0;
    #0.5;
    chk("R5 async phase", 64'(phase), 64'h0);
    chk("R5 async top", 64'(phaseTop), 64'h0);
    @(negedge clk);
    rstN = 1'b1;

    // phase continuity across a step change
    doReset();
    phaseInc = 48'h0000_0100_0000;
    for (int k = 0; k < 4; k++) step();
    phaseInc = 48'h0000_0000_0030;
    step();
    chk("R6 continuity", 64'(phase), 64'h0000_0400_0030);
    step();
    chk("R6 continuity 2", 64'(phase), 64'h0000_0400_0060);

    // single-cycle pulse: wrap then no wrap
    doReset();
    phaseInc = 48'hC000_0000_0000;
    step();
    chk("R3 no wrap", 64'(carryOut), 64'h0);
    step();
    chk("R3 wrap pulse", 64'(carryOut), 64'h1);
    phaseInc = '0;
    step();
    chk("R3 pulse ends", 64'(carryOut), 64'h0);

    // cascade: high unit counts low wraps one cycle late
    doReset();
    phaseInc = 48'h8000_0000_0000;
    carryIn  = 1'b0;
    carries  = 0;
    for (int k = 0; k < 10; k++) begin
      step();
      chk("R7 cascade high word", 64'(hiPhase), 64'(carries));
      carries += int'(carryOut);
    end
    chk("R7 wrap count", 64'(carries), 64'd5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule